// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Shift Engine

This block moves one frame at a time between a transmit FIFO and a receive FIFO over a four-wire synchronous serial link. Each frame carries 4 to 16 bits, most significant bit first. The link runs in one of three formats:

- **Clock-polarity/phase format:** the four classic polarity/phase combinations.
- **Frame-pulse format:** a synchronous format in which a one-period sync pulse comes before each word.
- **Command/response format:** half duplex. An 8-bit command goes out, the link idles for one clock, and then a response of the frame width comes back.

As master, the block makes the serial clock and the select line, advancing one half-period for each pulse on `bit_en`. That pulse comes from a separate baud generator. As slave, it follows an external clock and an active-low select in the polarity/phase format. In this mode it can keep its serial output released.

Software or a DMA engine feeds the block through a push port and drains it through a pop port with a show-ahead head word. Three flags support polled use: transmit-not-full, receive-not-empty and busy. Configuration is expected to stay stable while `busy` is high.

Top module: `sser_engine`

## Requirements
- R1: In format 0 (`cfg_fmt`=0) the idle serial clock level equals `cfg_cpol`. With `cfg_cpha`=0, both sides sample on the leading edge (away from idle) and change data on the trailing edge. With `cfg_cpha`=1, they change data on the leading edge and sample on the trailing edge.
- R2: The frame width is `cfg_wm1`+1 bits (4 to 16), sent and received most significant bit first.
- R3: Transmit bits at or above the frame width are ignored. A received word holds its data in the low width bits, and its upper bits read zero.
- R4: As master in format 0, the select output `sel_o` is low for the whole frame and high while idle. The serial clock moves only while select is low.
- R5: In format 1 (frame pulse) the clock idles low and `sel_o` acts as sync, idling low. Sync is high for exactly one serial clock period, with one rising edge, and falls just before the first data bit. Data changes on rising edges and is sampled on falling edges.
- R6: In format 2 (command/response) select is low for the frame. Bits 7..0 of the transmit word are sent MSB first, then one idle clock period follows. A response of the frame width is then sampled on rising edges and queued for reading.
- R7: As slave (`cfg_slave`=1, format 0 only), a frame starts when `sel_i` falls. The block pops one transmit word, or sends zeros if the FIFO is empty, shifts on the edges of `sclk_i`, and queues the received word.
- R8: As slave with `cfg_odis`=1, `sdo_oe` stays low at all times. In master mode `sdo_oe` is high.
- R9: `busy` is high while the transmit FIFO holds a word or a frame is under way. It falls only after the last bit of the last word has been shifted.
- R10: `tx_not_full` is low when DEPTH words are queued for transmit, and a push while it is low is dropped.
- R11: `rx_not_empty` is high while a received word is waiting. `rx_data` shows the oldest such word, and `rx_pop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Half-bit-period enable from the baud generator (master) |
| cfg_slave | input | 1 | 1 = slave, 0 = master |
| cfg_odis | input | 1 | Slave output disable |
| cfg_fmt | input | 2 | 0 polarity/phase, 1 frame pulse, 2 command/response |
| cfg_cpol | input | 1 | Clock idle level (format 0) |
| cfg_cpha | input | 1 | Clock phase (format 0) |
| cfg_wm1 | input | 4 | Frame width minus one |
| tx_push | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 16 | Word to transmit |
| tx_not_full | output | 1 | Transmit FIFO has room |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_data | output | 16 | Head of the receive FIFO |
| rx_not_empty | output | 1 | Receive FIFO holds a word |
| busy | output | 1 | Transfer pending or in progress |
| sclk_o | output | 1 | Serial clock (master) |
| sel_o | output | 1 | Select, active low, or sync pulse (master) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sclk_i | input | 1 | Serial clock (slave) |
| sel_i | input | 1 | Select, active low (slave) |
| sdi | input | 1 | Serial data in |

## Verification
The bench scores each frame as its last edge completes. A corrupted shift register or slot counter therefore shows up as a wrong word or a missing frame within one frame time. A wrong phase decision shows as bits shifted by one position in both directions.

A state machine stuck outside idle keeps `busy` high and stalls the drain loop. A clock edge outside select trips the frame checks on the next serial edge. Flag and FIFO-count faults surface when the fifth push is accepted or when a queued word is not visible before popping.

// File: rtl/sser_engine.sv
module sser_engine #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        cfg_slave,
  input  logic        cfg_odis,
  input  logic [1:0]  cfg_fmt,
  input  logic        cfg_cpol,
  input  logic        cfg_cpha,
  input  logic [3:0]  cfg_wm1,
  input  logic        tx_push,
  input  logic [15:0] tx_data,
  output logic        tx_not_full,
  input  logic        rx_pop,
  output logic [15:0] rx_data,
  output logic        rx_not_empty,
  output logic        busy,
  output logic        sclk_o,
  output logic        sel_o,
  output logic        sdo,
  output logic        sdo_oe,
  input  logic        sclk_i,
  input  logic        sel_i,
  input  logic        sdi
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] F_FP = 2'd1, F_CR = 2'd2, F_PP = 2'd0;
  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_XFER, S_DONE} st_t;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [15:0]   txm [DEPTH];
  logic [15:0]   rxm [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt, rcnt;
  logic          tx_wr, tx_rd, rx_wr, rx_rd;

  st_t         st;
  logic        sclk_r, sel_r;
  logic [4:0]  slot;
  logic [15:0] shreg, rxs, rxs_nx, ld;
  logic [2:0]  sck_m, sel_m;

  wire [15:0] tx_head = txm[trp];
  wire [15:0] wmask   = 16'hFFFF >> (4'd15 - cfg_wm1);
  wire [4:0]  w       = {1'b0, cfg_wm1} + 5'd1;
  wire        fp      = cfg_fmt == F_FP;
  wire        cr      = cfg_fmt == F_CR;
  wire        pol     = (cfg_fmt == F_PP) ? cfg_cpol : 1'b0;
  wire        pha     = fp || (cfg_fmt == F_PP && cfg_cpha);
  wire [4:0]  nslots  = cr ? w + 5'd9 : w;

  wire sck_s = sck_m[1], sck_p = sck_m[2];
  wire sel_s = sel_m[1], sel_p = sel_m[2];

  wire ev      = cfg_slave ? (sck_s != sck_p) : bit_en;
  wire lead    = cfg_slave ? (sck_s != pol) : (sclk_r == pol);
  wire act     = (st == S_XFER) && ev;
  wire samp    = act && (lead ? !pha : pha) && (!cr || slot >= 5'd9);
  wire shf     = act && (lead ? (pha && slot != 5'd0) : !pha);
  wire fin     = act && !lead && (slot + 5'd1 == nslots);
  wire m_start = !cfg_slave && st == S_IDLE && bit_en && tcnt != '0;
  wire s_start = cfg_slave && st == S_IDLE && !sel_s && sel_p;
  wire abort   = cfg_slave && st != S_IDLE && sel_s;

  assign ld           = cr ? {tx_head[7:0], 8'h00} : ((tx_head & wmask) << (4'd15 - cfg_wm1));
  assign rxs_nx       = samp ? {rxs[14:0], sdi} : rxs;
  assign tx_not_full  = tcnt != CW'(DEPTH);
  assign rx_not_empty = rcnt != '0;
  assign tx_wr        = tx_push && tx_not_full;
  assign tx_rd        = m_start || (s_start && tcnt != '0);
  assign rx_wr        = fin && rcnt != CW'(DEPTH);
  assign rx_rd        = rx_pop && rx_not_empty;
  assign rx_data      = rxm[rrp];
  assign busy         = tcnt != '0 || st != S_IDLE;
  assign sclk_o       = (cfg_slave || st == S_IDLE) ? pol : sclk_r;
  assign sel_o        = (cfg_slave || st == S_IDLE) ? !fp : sel_r;
  assign sdo          = shreg[15];
  assign sdo_oe       = cfg_slave ? (st != S_IDLE && !cfg_odis) : 1'b1;

  always_ff @(posedge clk) begin
    if (tx_wr) txm[twp] <= tx_data & wmask;
    if (rx_wr) rxm[rwp] <= rxs_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (tx_wr) twp <= nxt(twp);
      if (tx_rd) trp <= nxt(trp);
      if (rx_wr) rwp <= nxt(rwp);
      if (rx_rd) rrp <= nxt(rrp);
      tcnt <= tcnt + CW'(tx_wr) - CW'(tx_rd);
      rcnt <= rcnt + CW'(rx_wr) - CW'(rx_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sclk_r <= 1'b0; sel_r <= 1'b1; slot <= '0;
      shreg <= '0; rxs <= '0; sck_m <= '0; sel_m <= '1;
    end else begin
      sck_m <= {sck_m[1:0], sclk_i};
      sel_m <= {sel_m[1:0], sel_i};
      rxs   <= rxs_nx;
      if (shf) shreg <= {shreg[14:0], 1'b0};
      if (abort) st <= S_IDLE;
      else begin
        case (st)
          S_IDLE: if (m_start || s_start) begin
            st     <= (m_start && fp) ? S_PULSE : S_XFER;
            sel_r  <= m_start && fp;
            sclk_r <= pol;
            slot   <= '0;
            rxs    <= '0;
            shreg  <= (tcnt != '0) ? ld : '0;
          end
          S_PULSE: if (bit_en) begin
            sclk_r <= ~sclk_r;
            if (sclk_r) begin
              sel_r <= 1'b0;
              st    <= S_XFER;
            end
          end
          S_XFER: if (act) begin
            sclk_r <= lead ? ~pol : pol;
            if (!lead) slot <= slot + 5'd1;
            if (fin) begin
              st    <= cfg_slave ? S_DONE : S_IDLE;
              sel_r <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sser_engine_chk.sv
module sser_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_slave,
  input logic        cfg_odis,
  input logic [1:0]  cfg_fmt,
  input logic        cfg_cpol,
  input logic [3:0]  cfg_wm1,
  input logic [15:0] rx_data,
  input logic        rx_not_empty,
  input logic        busy,
  input logic        sclk_o,
  input logic        sel_o,
  input logic        sdo_oe
);
  AST_ODIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slave && cfg_odis) |-> !sdo_oe); // R8

  AST_RX_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_not_empty |-> ((rx_data >> ({1'b0, cfg_wm1} + 5'd1)) == 16'h0)); // R3

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && cfg_fmt == 2'd0 && $stable(cfg_cpol) && $stable(cfg_fmt) &&
     $stable(cfg_slave) && !$stable(sclk_o)) |-> !$past(sel_o)); // R4

  AST_FRAME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && cfg_fmt != 2'd1 && !sel_o) |-> busy); // R9
endmodule

bind sser_engine sser_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_odis(cfg_odis),
  .cfg_fmt(cfg_fmt), .cfg_cpol(cfg_cpol), .cfg_wm1(cfg_wm1),
  .rx_data(rx_data), .rx_not_empty(rx_not_empty), .busy(busy),
  .sclk_o(sclk_o), .sel_o(sel_o), .sdo_oe(sdo_oe)
);

// File: tb/tb_sser_engine.sv
module tb_sser_engine;
  localparam int DEPTH = 4;
  logic clk = 0, rst_n = 0, bit_en = 0;
  logic cfg_slave = 0, cfg_odis = 0, cfg_cpol = 0, cfg_cpha = 0;
  logic [1:0] cfg_fmt = 0;
  logic [3:0] cfg_wm1 = 4'd7;
  logic tx_push = 0, rx_pop = 0, sclk_i = 0, sel_i = 1, sdi = 0;
  logic [15:0] tx_data = 0, rx_data;
  logic tx_not_full, rx_not_empty, busy, sclk_o, sel_o, sdo, sdo_oe;

  always #2 clk = ~clk;

  sser_engine #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_slave(cfg_slave), .cfg_odis(cfg_odis),
    .cfg_fmt(cfg_fmt), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_wm1(cfg_wm1),
    .tx_push(tx_push), .tx_data(tx_data), .tx_not_full(tx_not_full), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_not_empty(rx_not_empty), .busy(busy), .sclk_o(sclk_o),
    .sel_o(sel_o), .sdo(sdo), .sdo_oe(sdo_oe), .sclk_i(sclk_i), .sel_i(sel_i), .sdi(sdi));

  int n_chk = 0, n_bad = 0, frames = 0;
  bit en_run = 0, peer_on = 0, rx_auto = 1;
  string cur_req = "R1";
  logic [15:0] exp_tx_q[$], peer_q[$], exp_rx_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wid();
    return int'(cfg_wm1) + 1;
  endfunction

  function automatic logic [15:0] msk();
    return 16'hFFFF >> (15 - int'(cfg_wm1));
  endfunction

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div++;
      bit_en = en_run && (div % 3 == 0);
    end
  end

  // Scoreboard monitor: received words
  initial begin
    forever begin
      @(negedge clk);
      rx_pop = 0;
      if (rx_auto && rx_not_empty) begin
        if (exp_rx_q.size() == 0) check(cur_req, {16'h0, rx_data}, 32'hFFFF_FFFF);
        else check(cur_req, {16'h0, rx_data}, {16'h0, exp_rx_q.pop_front()});
        rx_pop = 1;
      end
    end
  end

  // Scoreboard monitor: serial peer of the master
  initial begin
    logic ps = 0, pe = 1, inf = 0, ld, pl, ph;
    logic [15:0] cap = 0, outw = 0;
    int lc = 0, tc = 0, pr = 0, w;
    forever begin
      @(negedge clk);
      w  = wid();
      pl = (cfg_fmt == 0) ? cfg_cpol : 1'b0;
      ph = (cfg_fmt == 1) || (cfg_fmt == 0 && cfg_cpha);
      if (peer_on) begin
        if (cfg_fmt == 1 && sel_o && sclk_o && !ps) pr++;
        if (pe && !sel_o) begin
          inf = 1; lc = 0; tc = 0; cap = 0;
          outw = (peer_q.size() != 0) ? peer_q.pop_front() : 16'h0;
          if (cfg_fmt == 1) begin check("R5", pr, 1); pr = 0; end
          if (cfg_fmt == 0 && !ph) sdi = outw[w-1];
          if (cfg_fmt == 2) sdi = 0;
        end else if (inf && sclk_o != ps) begin
          ld = sclk_o != pl;
          if (cfg_fmt == 2) begin
            if (ld) begin if (lc < 8) cap = {cap[14:0], sdo}; lc++; end
            else begin
              tc++;
              if (tc >= 9 && tc - 9 < w) sdi = outw[w-1-(tc-9)];
              if (tc == w + 9) begin
                inf = 0; frames++;
                check("R6", {31'h0, sel_o}, 1);
                if (exp_tx_q.size() == 0) check("R6", cap, 32'hFFFF_FFFF);
                else check("R6", cap, exp_tx_q.pop_front());
              end
            end
          end else begin
            if (ld) begin
              if (!ph) cap = {cap[14:0], sdo};
              else if (lc < w) sdi = outw[w-1-lc];
              lc++;
            end else begin
              if (ph) cap = {cap[14:0], sdo};
              else if (tc + 1 < w) sdi = outw[w-2-tc];
              tc++;
              if (tc == w) begin
                inf = 0; frames++;
                if (cfg_fmt == 0) check("R4", {31'h0, sel_o}, 1);
                if (exp_tx_q.size() == 0) check(cur_req, cap, 32'hFFFF_FFFF);
                else check(cur_req, cap, exp_tx_q.pop_front());
              end
            end
          end
        end
      end
      ps = sclk_o;
      pe = sel_o;
    end
  end

  task automatic push_raw(logic [15:0] d);
    @(negedge clk);
    while (!tx_not_full) @(negedge clk);
    tx_push = 1; tx_data = d;
    @(negedge clk);
    tx_push = 0;
  endtask

  // Driver: queues expectations, then pushes the word
  task automatic send(logic [15:0] d, logic [15:0] resp);
    exp_tx_q.push_back(cfg_fmt == 2 ? {8'h0, d[7:0]} : (d & msk()));
    peer_q.push_back(resp & msk());
    exp_rx_q.push_back(resp & msk());
    push_raw(d);
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy || exp_tx_q.size() != 0 || exp_rx_q.size() != 0 || rx_not_empty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic setcfg(logic [1:0] f, logic p, logic h, logic [3:0] wm, logic sl, logic od);
    peer_on = 0;
    @(negedge clk);
    cfg_fmt = f; cfg_cpol = p; cfg_cpha = h; cfg_wm1 = wm; cfg_slave = sl; cfg_odis = od;
    repeat (3) @(negedge clk);
    peer_on = !sl;
  endtask

  task automatic slave_xfer(logic [15:0] to_s, logic [15:0] exp_s, bit chk_oe);
    logic [15:0] got = 0;
    int w = wid();
    exp_rx_q.push_back(to_s & msk());
    sclk_i = cfg_cpol;
    if (!cfg_cpha) sdi = to_s[w-1];
    sel_i = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < w; i++) begin
      if (!cfg_cpha) got = {got[14:0], sdo};
      sclk_i = ~cfg_cpol;
      if (cfg_cpha) sdi = to_s[w-1-i];
      repeat (8) @(negedge clk);
      if (cfg_cpha) got = {got[14:0], sdo};
      if (chk_oe) check("R8", {31'h0, sdo_oe}, 0);
      sclk_i = cfg_cpol;
      if (!cfg_cpha && i + 1 < w) sdi = to_s[w-2-i];
      repeat (8) @(negedge clk);
    end
    check("R7", got, exp_s & msk());
    sel_i = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int f0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9", {31'h0, busy}, 0);
    check("R10", {31'h0, tx_not_full}, 1);
    check("R11", {31'h0, rx_not_empty}, 0);
    check("R4", {31'h0, sel_o}, 1);
    check("R1", {31'h0, sclk_o}, 0);
    en_run = 1;

    for (int m = 0; m < 4; m++) begin
      cur_req = "R1";
      setcfg(2'd0, m[1], m[0], 4'd7, 0, 0);
      check("R1", {31'h0, sclk_o}, {31'h0, m[1]});
      send(16'h00A5 ^ 16'(m), 16'h003C + 16'(m));
      send(16'h0081, 16'h00E7);
      drain();
    end

    cur_req = "R3";
    setcfg(2'd0, 0, 1, 4'd3, 0, 0);
    send(16'hFFA5, 16'hFFF9);
    drain();
    cur_req = "R2";
    setcfg(2'd0, 1, 0, 4'd15, 0, 0);
    send(16'hA5C3, 16'h3CE1);
    drain();

    cur_req = "R9";
    setcfg(2'd0, 0, 0, 4'd7, 0, 0);
    en_run = 0;
    f0 = frames;
    send(16'h0012, 16'h0034);
    send(16'h0056, 16'h0078);
    check("R9", {31'h0, busy}, 1);
    en_run = 1;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R9", frames - f0, 2);
    drain();

    cur_req = "R10";
    en_run = 0;
    for (int i = 0; i < DEPTH; i++) send(16'h0040 + 16'(i), 16'h0090 + 16'(i));
    check("R10", {31'h0, tx_not_full}, 0);
    @(negedge clk); tx_push = 1; tx_data = 16'h00EE;
    @(negedge clk); tx_push = 0;
    check("R10", {31'h0, tx_not_full}, 0);
    f0 = frames;
    en_run = 1;
    drain();
    repeat (100) @(negedge clk);
    check("R10", frames - f0, DEPTH);

    cur_req = "R11";
    rx_auto = 0;
    send(16'h005A, 16'h00C3);
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R11", {31'h0, rx_not_empty}, 1);
    check("R11", {16'h0, rx_data}, 32'h00C3);
    rx_auto = 1;
    drain();
    check("R11", {31'h0, rx_not_empty}, 0);

    cur_req = "R5";
    setcfg(2'd1, 0, 0, 4'd7, 0, 0);
    check("R5", {31'h0, sel_o}, 0);
    send(16'h00B4, 16'h0069);
    send(16'h0033, 16'h00CC);
    drain();

    cur_req = "R6";
    setcfg(2'd2, 0, 0, 4'd11, 0, 0);
    send(16'h12C4, 16'h03A5);
    send(16'h0071, 16'h0F0F);
    drain();

    cur_req = "R7";
    en_run = 0;
    setcfg(2'd0, 0, 1, 4'd7, 1, 0);
    push_raw(16'h005A);
    check("R9", {31'h0, busy}, 1);
    slave_xfer(16'h00C3, 16'h005A, 0);
    setcfg(2'd0, 1, 0, 4'd7, 1, 0);
    push_raw(16'h0096);
    slave_xfer(16'h0017, 16'h0096, 0);
    drain();

    cur_req = "R8";
    setcfg(2'd0, 0, 0, 4'd7, 1, 1);
    push_raw(16'h00F0);
    slave_xfer(16'h0081, 16'h00F0, 1);
    drain();
    check("R8", {31'h0, sdo_oe}, 0);

    finish_up();
  end
endmodule